// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port memory. Ports A and B each have their own clock and can read or write any word of one shared array in the same cycle. Every port captures its enables, write select, address and write data in registers on the rising edge of its own clock. The address used for the access always comes from a per-port burst counter. The counter can be cleared, loaded from the address pins, or stepped by one. A caller can therefore stream a run of consecutive words with a single load followed by count-enable cycles. The counter wraps from the top of the array back to word zero.

A static mode input, shared by both ports, selects the read path. In flow-through mode, read data is presented in the cycle after the capture edge. In pipelined mode, an extra output register delays it by one more cycle. Instead of a high-impedance bus, each port drives a data-valid flag. A port is deselected when its active-low enable is high or its active-high enable is low. In pipelined mode, a port coming back from deselect needs one selected cycle before its flag rises again. `DEPTH` is normally 16384, 32768 or 65536, and `DW` is 16 or 18. The small default depth only keeps elaboration light.

Top module: `dual_port_burst_ram`

## Requirements
- R1: Each port reads and writes any word through its own registered inputs, and a read returns the most recent value written to that word by either port.
- R2: With `pipe_mode`=0 (flow-through), a read captured at rising edge k drives its port's data and a high valid flag in the cycle after edge k, until edge k+1.
- R3: With `pipe_mode`=1 (pipelined), the same read appears one cycle later, in the cycle after edge k+1. The mode input applies to both ports.
- R4: A port captured with its active-low enable at 1 or its active-high enable at 0 does not write, and its valid flag is 0 for that access.
- R5: In pipelined mode, a read captured at the edge after a deselected capture, or at the first edge after reset, does not raise the valid flag. The next read does.
- R6: Counter control is sampled at each rising edge, all controls active low, with priority clear (to 0), then load (from the address pins), then step (+1), otherwise hold. The control acts whatever the enables are.
- R7: The access address of a capture is the counter value that this same edge produces.
- R8: Stepping from word DEPTH-1 gives word 0.
- R9: When both ports write the same word in the same cycle (common clock), port A's data is stored.
- R10: A read on one port in the cycle the other port writes the same word returns the old data. A later read returns the new data.
- R11: While `rst_n` is low, both counters are 0 and both valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of port registers and counters |
| pipe_mode | input | 1 | 1 selects the pipelined read path, 0 flow-through; static, shared |
| a_clk | input | 1 | Port A clock |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_wr | input | 1 | Port A 1 = write, 0 = read |
| a_adr | input | $clog2(DEPTH) | Port A counter load value |
| a_din | input | DW | Port A write data |
| a_load_n | input | 1 | Port A counter load, active low |
| a_step_n | input | 1 | Port A counter increment, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_dout | output | DW | Port A read data (0 when not valid) |
| a_dvld | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_wr | input | 1 | Port B 1 = write, 0 = read |
| b_adr | input | $clog2(DEPTH) | Port B counter load value |
| b_din | input | DW | Port B write data |
| b_load_n | input | 1 | Port B counter load, active low |
| b_step_n | input | 1 | Port B counter increment, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_dout | output | DW | Port B read data (0 when not valid) |
| b_dvld | output | 1 | Port B read data valid |

## Verification
A counter that holds a wrong value does not show up by itself. It shows up as wrong read data from the moment the next read uses that address: one cycle after the edge in flow-through mode, two in pipelined mode. A corrupted ownership bit in the two-bank store is the same: it stays hidden until the affected word is read back, and then the port shows the stale bank's value. A wrong select or reactivation state shows up at once, within the same one or two cycles, as a valid flag that is high or low in the wrong cycle. For this reason the bench fills the whole array first and then compares every read against a reference model.

// File: rtl/dpb_pkg.sv
`timescale 1ns/1ps
package dpb_pkg;

    localparam int NPORT = 2;

    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_STEP  = 2'd1,
        CTR_LOAD  = 2'd2,
        CTR_CLEAR = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/dpb_ctr.sv
`timescale 1ns/1ps
// Next-value logic of one burst address counter.
module dpb_ctr
    import dpb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] ext,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic          step_n,
    output logic [AW-1:0] nxt
);

    ctr_op_e op;

    always_comb begin
        if (!clr_n)       op = CTR_CLEAR;
        else if (!load_n) op = CTR_LOAD;
        else if (!step_n) op = CTR_STEP;
        else              op = CTR_HOLD;
    end

    always_comb begin
        unique case (op)
            CTR_CLEAR: nxt = '0;
            CTR_LOAD:  nxt = ext;
            CTR_STEP:  nxt = cur + AW'(1);   // power-of-two depth: natural wrap
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/dpb_port.sv
`timescale 1ns/1ps
// One access port: input capture, burst counter, output stage.
module dpb_port
    import dpb_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          en_n,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] adr,
    input  logic [DW-1:0] din,
    input  logic          load_n,
    input  logic          step_n,
    input  logic          clr_n,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] acc_addr,
    output logic          acc_we,
    output logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] dout,
    output logic          dvld
);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          act;
        logic          wr;
        logic [DW-1:0] wdata;
        logic          act_prev;
        logic [DW-1:0] pdata;
        logic          pvld;
    } st_t;

    st_t           st_d, st_q;
    logic [AW-1:0] cnt_nxt;
    rd_mode_e      mode;
    logic          flow_vld;
    logic [DW-1:0] sel_data;

    dpb_ctr #(.AW(AW)) u_ctr (
        .cur    (st_q.cnt),
        .ext    (adr),
        .clr_n  (clr_n),
        .load_n (load_n),
        .step_n (step_n),
        .nxt    (cnt_nxt)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cnt      = cnt_nxt;
        st_d.act      = ~en_n & en;
        st_d.wr       = wr;
        st_d.wdata    = din;
        st_d.act_prev = st_q.act;
        st_d.pdata    = rd_data;
        st_d.pvld     = st_q.act & ~st_q.wr & st_q.act_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode      = rd_mode_e'(pipe_mode);
    assign flow_vld  = st_q.act & ~st_q.wr;
    assign acc_addr  = st_q.cnt;
    assign acc_we    = st_q.act & st_q.wr;
    assign acc_wdata = st_q.wdata;

    always_comb begin
        if (mode == MODE_PIPE) begin
            dvld     = st_q.pvld;
            sel_data = st_q.pdata;
        end else begin
            dvld     = flow_vld;
            sel_data = rd_data;
        end
        dout = dvld ? sel_data : '0;
    end

endmodule

// File: rtl/dpb_store.sv
`timescale 1ns/1ps
// Two-writer storage: one bank per writing port plus one ownership bit
// per bank and word; each array has exactly one writing clock.
module dpb_store
    import dpb_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       a_clk,
    input  logic                       b_clk,
    input  logic [NPORT-1:0][AW-1:0]   addr,
    input  logic [NPORT-1:0]           we,
    input  logic [NPORT-1:0][DW-1:0]   wdata,
    output logic [NPORT-1:0][DW-1:0]   rdata
);

    logic [DW-1:0] bank_a [DEPTH];
    logic [DW-1:0] bank_b [DEPTH];
    logic          own_a  [DEPTH];
    logic          own_b  [DEPTH];
    logic          b_yield;

    // Same-word write in the same cycle: port B steps aside.
    assign b_yield = we[0] && we[1] && (addr[0] == addr[1]);

    always_ff @(posedge a_clk) begin
        if (we[0]) begin
            bank_a[addr[0]] <= wdata[0];
            own_a[addr[0]]  <= own_b[addr[0]];
        end
    end

    always_ff @(posedge b_clk) begin
        if (we[1] && !b_yield) begin
            bank_b[addr[1]] <= wdata[1];
            own_b[addr[1]]  <= ~own_a[addr[1]];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdata[p] = (own_a[addr[p]] == own_b[addr[p]]) ? bank_a[addr[p]]
                                                             : bank_b[addr[p]];
    end

endmodule

// File: rtl/dual_port_burst_ram.sv
`timescale 1ns/1ps
module dual_port_burst_ram
    import dpb_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          a_clk,
    input  logic          a_en_n,
    input  logic          a_en,
    input  logic          a_wr,
    input  logic [AW-1:0] a_adr,
    input  logic [DW-1:0] a_din,
    input  logic          a_load_n,
    input  logic          a_step_n,
    input  logic          a_clr_n,
    output logic [DW-1:0] a_dout,
    output logic          a_dvld,
    input  logic          b_clk,
    input  logic          b_en_n,
    input  logic          b_en,
    input  logic          b_wr,
    input  logic [AW-1:0] b_adr,
    input  logic [DW-1:0] b_din,
    input  logic          b_load_n,
    input  logic          b_step_n,
    input  logic          b_clr_n,
    output logic [DW-1:0] b_dout,
    output logic          b_dvld
);

    logic [NPORT-1:0]         clk_v, en_n_v, en_v, wr_v, load_n_v, step_n_v, clr_n_v;
    logic [NPORT-1:0][AW-1:0] adr_v, acc_addr;
    logic [NPORT-1:0][DW-1:0] din_v, wdata_v, rd_v, dout_v;
    logic [NPORT-1:0]         we_v, dvld_v;

    assign clk_v    = {b_clk,    a_clk};
    assign en_n_v   = {b_en_n,   a_en_n};
    assign en_v     = {b_en,     a_en};
    assign wr_v     = {b_wr,     a_wr};
    assign load_n_v = {b_load_n, a_load_n};
    assign step_n_v = {b_step_n, a_step_n};
    assign clr_n_v  = {b_clr_n,  a_clr_n};
    assign adr_v    = {b_adr,    a_adr};
    assign din_v    = {b_din,    a_din};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpb_port #(.AW(AW), .DW(DW)) u_port (
            .clk       (clk_v[p]),
            .rst_n     (rst_n),
            .pipe_mode (pipe_mode),
            .en_n      (en_n_v[p]),
            .en        (en_v[p]),
            .wr        (wr_v[p]),
            .adr       (adr_v[p]),
            .din       (din_v[p]),
            .load_n    (load_n_v[p]),
            .step_n    (step_n_v[p]),
            .clr_n     (clr_n_v[p]),
            .rd_data   (rd_v[p]),
            .acc_addr  (acc_addr[p]),
            .acc_we    (we_v[p]),
            .acc_wdata (wdata_v[p]),
            .dout      (dout_v[p]),
            .dvld      (dvld_v[p])
        );
    end

    dpb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .a_clk (a_clk),
        .b_clk (b_clk),
        .addr  (acc_addr),
        .we    (we_v),
        .wdata (wdata_v),
        .rdata (rd_v)
    );

    assign a_dout = dout_v[0];
    assign a_dvld = dvld_v[0];
    assign b_dout = dout_v[1];
    assign b_dvld = dvld_v[1];

endmodule

// File: rtl/dpb_chk.sv
`timescale 1ns/1ps
module dpb_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic                rst_n,
    input logic                pipe_mode,
    input logic                a_clk,
    input logic                a_en_n,
    input logic                a_en,
    input logic                a_wr,
    input logic [AW-1:0]       a_adr,
    input logic                a_load_n,
    input logic                a_step_n,
    input logic                a_clr_n,
    input logic                a_dvld,
    input logic                b_clk,
    input logic                b_clr_n,
    input logic [1:0][AW-1:0]  acc_addr
);

    AST_A_CLEAR: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_clr_n |=> acc_addr[0] == '0); // R6
    AST_B_CLEAR: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_clr_n |=> acc_addr[1] == '0); // R6
    AST_A_LOAD: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && !a_load_n) |=> acc_addr[0] == $past(a_adr)); // R7
    AST_A_STEP: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && a_load_n && !a_step_n) |=> acc_addr[0] == AW'($past(acc_addr[0]) + 1'b1)); // R6
    AST_A_HOLD: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && a_load_n && a_step_n) |=> $stable(acc_addr[0])); // R6
    AST_A_WRAP: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && a_load_n && !a_step_n && acc_addr[0] == AW'(DEPTH - 1)) |=> acc_addr[0] == '0); // R8
    AST_FLOW_READ: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!pipe_mode && !a_en_n && a_en && !a_wr) |-> ##1 a_dvld); // R2
    AST_FLOW_DESEL: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!pipe_mode && (a_en_n || !a_en)) |-> ##1 !a_dvld); // R4
    AST_PIPE_DESEL: assert property (@(posedge a_clk) disable iff (!rst_n)
        (pipe_mode && (a_en_n || !a_en)) |-> ##2 !a_dvld); // R4
    AST_PIPE_REACT: assert property (@(posedge a_clk) disable iff (!rst_n)
        (pipe_mode && (a_en_n || !a_en)) |-> ##3 !a_dvld); // R5

endmodule

bind dual_port_burst_ram dpb_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .a_clk     (a_clk),
    .a_en_n    (a_en_n),
    .a_en      (a_en),
    .a_wr      (a_wr),
    .a_adr     (a_adr),
    .a_load_n  (a_load_n),
    .a_step_n  (a_step_n),
    .a_clr_n   (a_clr_n),
    .a_dvld    (a_dvld),
    .b_clk     (b_clk),
    .b_clr_n   (b_clr_n),
    .acc_addr  (acc_addr)
);

// File: tb/sim_dual_port_burst_ram.sv
`timescale 1ns/1ps
module sim_dual_port_burst_ram;

    localparam int DW    = 16;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic          d_en_n [2], d_en [2], d_wr [2], d_load_n [2], d_step_n [2], d_clr_n [2];
    logic [AW-1:0] d_adr [2];
    logic [DW-1:0] d_din [2];
    logic [DW-1:0] a_dout, b_dout;
    logic          a_dvld, b_dvld;

    dual_port_burst_ram #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .rst_n(rst_n), .pipe_mode(mode),
        .a_clk(clk), .a_en_n(d_en_n[0]), .a_en(d_en[0]), .a_wr(d_wr[0]), .a_adr(d_adr[0]),
        .a_din(d_din[0]), .a_load_n(d_load_n[0]), .a_step_n(d_step_n[0]), .a_clr_n(d_clr_n[0]),
        .a_dout(a_dout), .a_dvld(a_dvld),
        .b_clk(clk), .b_en_n(d_en_n[1]), .b_en(d_en[1]), .b_wr(d_wr[1]), .b_adr(d_adr[1]),
        .b_din(d_din[1]), .b_load_n(d_load_n[1]), .b_step_n(d_step_n[1]), .b_clr_n(d_clr_n[1]),
        .b_dout(b_dout), .b_dvld(b_dvld)
    );

    // Reference model
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] m_cnt [2];
    bit            c_act [2], c_wr [2], p_act [2], p_wr [2], pp_act [2];
    logic [AW-1:0] c_adr [2];
    logic [DW-1:0] c_wd [2], c_rd [2], p_rd [2];

    int    n_chk = 0, n_bad = 0;
    bit    done = 1'b0;
    string ctx = "";

    function automatic logic [AW-1:0] ctr_next(logic [AW-1:0] cur, logic clr_n, logic load_n,
                                               logic step_n, logic [AW-1:0] ext);
        if (!clr_n)  return '0;
        if (!load_n) return ext;
        if (!step_n) return cur + AW'(1);
        return cur;
    endfunction

    function automatic logic [DW-1:0] pat(int i);
        return DW'(32'hA5C3 ^ (i * 37));
    endfunction

    task automatic check(string tag, int p, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s port %0d %s: got %h expected %h", tag, p, what, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < 2; p++) begin
            m_cnt[p] = '0; c_act[p] = 0; c_wr[p] = 0; p_act[p] = 0; p_wr[p] = 0; pp_act[p] = 0;
        end
    endtask

    task automatic set_port(int p, bit sel, bit wr, logic [AW-1:0] adr, logic [DW-1:0] din,
                            bit load_n, bit step_n, bit clr_n);
        d_en_n[p] = ~sel; d_en[p] = sel; d_wr[p] = wr; d_adr[p] = adr; d_din[p] = din;
        d_load_n[p] = load_n; d_step_n[p] = step_n; d_clr_n[p] = clr_n;
    endtask

    task automatic idle_all();
        for (int p = 0; p < 2; p++) set_port(p, 0, 0, '0, '0, 1, 1, 1);
    endtask

    // One clock: model update at the rising edge, output check at the falling edge.
    task automatic tick();
        bit            ev;
        logic [DW-1:0] ed;
        logic [DW-1:0] gd;
        logic          gv;
        string         tag;
        @(posedge clk);
        if (c_act[1] && c_wr[1] && !(c_act[0] && c_wr[0] && c_adr[0] == c_adr[1]))
            ref_mem[c_adr[1]] = c_wd[1];
        if (c_act[0] && c_wr[0]) ref_mem[c_adr[0]] = c_wd[0];
        for (int p = 0; p < 2; p++) begin
            pp_act[p] = p_act[p]; p_act[p] = c_act[p]; p_wr[p] = c_wr[p]; p_rd[p] = c_rd[p];
            m_cnt[p]  = ctr_next(m_cnt[p], d_clr_n[p], d_load_n[p], d_step_n[p], d_adr[p]);
            c_act[p]  = !d_en_n[p] && d_en[p];
            c_wr[p]   = d_wr[p]; c_wd[p] = d_din[p]; c_adr[p] = m_cnt[p];
            c_rd[p]   = ref_mem[m_cnt[p]];
        end
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            if (mode) begin
                ev  = p_act[p] && !p_wr[p] && pp_act[p]; ed = p_rd[p];
                tag = (p_act[p] && !p_wr[p] && !pp_act[p]) ? "R5" : (!p_act[p] ? "R4" : "R3");
            end else begin
                ev  = c_act[p] && !c_wr[p]; ed = c_rd[p];
                tag = !c_act[p] ? "R4" : "R2";
            end
            if (ctx != "") tag = ctx;
            gv = (p == 0) ? a_dvld : b_dvld;
            gd = (p == 0) ? a_dout : b_dout;
            check(tag, p, "valid", DW'(gv), DW'(ev));
            if (ev) check((ctx != "") ? ctx : "R1", p, "data", gd, ed);
        end
    endtask

    task automatic do_reset(bit new_mode);
        rst_n = 1'b0;
        mode  = new_mode;
        idle_all();
        model_clear();
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11", 0, "valid in reset", DW'(a_dvld), '0);
        check("R11", 1, "valid in reset", DW'(b_dvld), '0);
        rst_n = 1'b1;
    endtask

    task automatic rand_cycles(int n);
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 2; p++)
                set_port(p, ($urandom % 8) != 0, ($urandom % 3) == 0, AW'($urandom % DEPTH),
                         DW'($urandom), ($urandom % 4) != 0, ($urandom % 2) != 0,
                         ($urandom % 32) != 0);
            if (($urandom % 16) == 0) begin   // provoke same-word activity
                d_load_n[1] = d_load_n[0]; d_step_n[1] = d_step_n[0]; d_clr_n[1] = d_clr_n[0];
                d_adr[1] = d_adr[0];
            end
            tick();
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0007));
        idle_all();
        model_clear();
        @(negedge clk);
        do_reset(1'b0);

        // R7 R8: fill the whole array through port A with one load and steps
        ctx = "R7";
        set_port(0, 1, 1, '0, pat(0), 0, 1, 1); tick();
        for (int i = 1; i < DEPTH; i++) begin set_port(0, 1, 1, '0, pat(i), 1, 0, 1); tick(); end
        ctx = "R8";
        set_port(0, 1, 0, '0, '0, 1, 0, 1); tick();   // steps past DEPTH-1 to word 0
        idle_all();
        // port B burst read across the top of the array
        set_port(1, 1, 0, AW'(DEPTH - 4), '0, 0, 1, 1); tick();
        for (int i = 0; i < 7; i++) begin set_port(1, 1, 0, '0, '0, 1, 0, 1); tick(); end
        // R6 priority: clear beats load, load beats step
        ctx = "R6";
        set_port(1, 1, 0, AW'(40), '0, 0, 0, 0); tick();
        set_port(1, 1, 0, AW'(40), '0, 0, 0, 1); tick();
        set_port(1, 1, 0, AW'(90), '0, 1, 1, 1); tick();       // hold keeps 40
        set_port(1, 0, 0, AW'(90), '0, 1, 0, 1); tick();       // step while deselected
        set_port(1, 1, 0, AW'(90), '0, 1, 1, 1); tick();       // reads word 41
        idle_all();
        // R9: same-word write collision, then read back on both ports
        ctx = "R9";
        set_port(0, 1, 1, AW'(12), 16'h1111, 0, 1, 1);
        set_port(1, 1, 1, AW'(12), 16'h2222, 0, 1, 1); tick();
        set_port(0, 1, 0, '0, '0, 1, 1, 1);
        set_port(1, 1, 0, '0, '0, 1, 1, 1); tick();
        // R10: read during the other port's write of the same word
        ctx = "R10";
        set_port(0, 1, 1, AW'(7), 16'h7777, 0, 1, 1);
        set_port(1, 1, 0, AW'(7), '0, 0, 1, 1); tick();
        set_port(0, 0, 0, '0, '0, 1, 1, 1);
        set_port(1, 1, 0, '0, '0, 1, 1, 1); tick();
        // R4: writes while deselected by either enable leave memory unchanged
        ctx = "R4";
        set_port(0, 0, 1, AW'(20), 16'hDEAD, 0, 1, 1); tick();
        set_port(0, 1, 1, AW'(21), 16'hBEEF, 0, 1, 1); d_en[0] = 1'b0; tick();
        set_port(0, 1, 0, AW'(20), '0, 0, 1, 1); tick();
        set_port(0, 1, 0, '0, '0, 1, 0, 1); tick();
        idle_all(); tick();
        // R11: counters return to word 0 after reset
        do_reset(1'b0);
        ctx = "R11";
        set_port(0, 1, 0, AW'(99), '0, 1, 1, 1);
        set_port(1, 1, 0, AW'(99), '0, 1, 1, 1); tick();
        ctx = "";
        rand_cycles(3000);

        // Pipelined mode
        do_reset(1'b1);
        ctx = "R5";
        set_port(0, 1, 0, AW'(3), '0, 0, 1, 1); tick();         // first after reset: no valid
        set_port(0, 1, 0, '0, '0, 1, 0, 1); tick();
        ctx = "R3";
        tick(); tick();
        ctx = "R5";
        set_port(0, 0, 0, '0, '0, 1, 1, 1); tick();
        set_port(0, 1, 0, '0, '0, 1, 0, 1); tick(); tick(); tick();
        ctx = "";
        rand_cycles(3000);

        idle_all(); tick(); tick();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
        $finish;
    end

endmodule